// File: doc/BRIEF.md
# Serial-Controlled Current-Sink DAC Front End

This block is the digital side of a 10-bit current-sink converter. It listens on a two-wire open-drain bus (I2C-compatible, no clock stretching) that it samples on a fast system clock. Both lines go through a synchronizer and a run-length filter, so short spikes are discarded. The block then finds start and stop conditions on the filtered lines, answers a fixed device address whose two low address bits are ignored, and moves a two-byte word to or from a 16-bit holding register.

The most significant byte goes on the bus first, and each byte is sent MSB first. A write only reaches the converter once the second data byte has been fully acknowledged. At that point the holding register is split into a 10-bit code and a soft power-down flag, and both are latched into the output register. A read sends the holding register back in the same bit order and then clears it.

The converter code stays at zero from reset until the first complete write. An external power-down pin is combined with the soft flag without passing through any clocked logic.

Top module: `isink_dac_link`

## Requirements
- R1: Any level on scl_i or sda_i that lasts fewer than FILT_LEN system clocks (6 by default, which is 60 ns at 100 MHz) is ignored. Such a pulse creates no clock edge, no start and no stop.
- R2: SDA falling while SCL is high is a start. SDA rising while SCL is high is a stop. A start at any point, including in the middle of a transfer, restarts address reception.
- R3: The address byte matches when its bits 7:3 equal 00011; bits 2:1 are don't care. Bit 0 selects the direction: 0 is a write, 1 is a read. On a match the block acknowledges by holding sda_oe_o high (pulling SDA low) through the ninth clock.
- R4: If the address does not match, the block gives no acknowledge, never asserts sda_oe_o, and ignores the bus until the next start.
- R5: Written bytes shift MSB first into a 16-bit holding register. Bit 15 is the soft power-down flag, bits 13:4 are the code, and bits 14 and 3:0 are unused. The code and the flag are latched for output only at the SCL falling edge that ends the acknowledge of the second data byte.
- R6: A start or stop that arrives before the second data byte's acknowledge has completed leaves dac_code_o and the soft flag unchanged.
- R7: A read sends holding-register bits 15:8 and then bits 7:0, each MSB first. sda_oe_o is high only for 0 bits. The block releases SDA on every ninth clock. A master ACK after the first byte continues the read; a NACK ends it.
- R8: After the second byte of a read has been sent, the holding register is cleared to zero. A read never changes dac_code_o.
- R9: After reset, dac_code_o is 0, the soft flag is 0 and sda_oe_o is 0.
- R10: pwr_down_o is the OR of pd_pin_i and the latched soft flag. It follows the pin combinationally, whatever the bus state.
- R11: Any byte after the second in a write is not acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| pd_pin_i | input | 1 | External power-down request, active high |
| dac_code_o | output | 10 | Converter code |
| pwr_down_o | output | 1 | Power-down to the analog part, active high |

## Verification
Two functions can land in the same cycle. One is the register update at the end of a write, which can clear the soft power-down flag. The other is the external power-down pin. To provoke this, the bench holds the pin high through a whole write whose second byte clears the soft flag, including the falling edge where that write takes effect. pwr_down_o must stay high through that edge, and must fall once the pin is released. A second pairing puts filter-length spikes on SDA while SCL is high, and on SCL while SCL is low, inside an acknowledged write. That write must still update the code exactly, with no false start, stop or extra clock.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_WDATA = 3'd2,
        PH_RDATA = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

endpackage

// File: rtl/sdac_line_filter.sv
module sdac_line_filter #(
    parameter int FILT_LEN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_st_t;

    flt_st_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = line_i;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 != flt_q.filt) begin
            if (flt_q.cnt == CW'(FILT_LEN - 1)) begin
                flt_d.filt = flt_q.s2;
                flt_d.cnt  = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + CW'(1);
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{s1: 1'b1, s2: 1'b1, filt: 1'b1, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.filt;

    logic sync_w;
    assign sync_w = flt_q.s2;

    AST_FILT_HELD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ($past(sync_w, 2) == line_o)); // R1

endmodule

// File: rtl/sdac_bus_events.sv
module sdac_bus_events
    import sdac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt_o
);
    typedef struct packed {
        logic scl_p;
        logic sda_p;
    } evt_st_t;

    evt_st_t ev_d, ev_q;

    always_comb begin
        ev_d.scl_p = scl_f;
        ev_d.sda_p = sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '{scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            ev_q <= ev_d;
        end
    end

    always_comb begin
        evt_o.start = scl_f && ev_q.scl_p && ev_q.sda_p && !sda_f;
        evt_o.stop  = scl_f && ev_q.scl_p && !ev_q.sda_p && sda_f;
        evt_o.rise  = scl_f && !ev_q.scl_p;
        evt_o.fall  = !scl_f && ev_q.scl_p;
        evt_o.sda   = sda_f;
    end

endmodule

// File: rtl/sdac_xfer_fsm.sv
module sdac_xfer_fsm
    import sdac_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0001100,
    parameter int         DC_BITS  = 2,
    parameter int         REG_W    = 16,
    parameter int         CODE_W   = 10,
    parameter int         CODE_LSB = 4,
    parameter int         PD_POS   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt_i,
    output logic              sda_oe_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              soft_pd_o
);
    localparam int MATCH_W = 7 - DC_BITS;

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        cnt;
        logic              byte_idx;
        logic              oe;
        logic              mack;
        logic [7:0]        ash;
        logic [REG_W-1:0]  inreg;
        logic [REG_W-1:0]  rsh;
        logic              dac_pd;
        logic [CODE_W-1:0] dac_code;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    addr_hit;

    assign addr_hit = (st_q.ash[7 -: MATCH_W] == DEV_ADDR[6 -: MATCH_W]);

    always_comb begin
        st_d = st_q;
        if (evt_i.start) begin
            st_d.phase    = PH_ADDR;
            st_d.cnt      = 4'd0;
            st_d.oe       = 1'b0;
            st_d.byte_idx = 1'b0;
        end else if (evt_i.stop) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = 4'd0;
            st_d.oe    = 1'b0;
        end else if (evt_i.rise) begin
            if ((st_q.phase == PH_ADDR || st_q.phase == PH_WDATA ||
                 st_q.phase == PH_RDATA) && st_q.cnt < 4'd9) begin
                st_d.cnt = st_q.cnt + 4'd1;
            end
            case (st_q.phase)
                PH_ADDR: begin
                    if (st_q.cnt < 4'd8) st_d.ash = {st_q.ash[6:0], evt_i.sda};
                end
                PH_WDATA: begin
                    if (st_q.cnt < 4'd8) st_d.inreg = {st_q.inreg[REG_W-2:0], evt_i.sda};
                end
                PH_RDATA: begin
                    if (st_q.cnt == 4'd8) st_d.mack = !evt_i.sda;
                end
                default: ;
            endcase
        end else if (evt_i.fall) begin
            case (st_q.phase)
                PH_ADDR: begin
                    if (st_q.cnt == 4'd8) begin
                        if (addr_hit) st_d.oe = 1'b1;
                        else          st_d.phase = PH_IDLE;
                    end else if (st_q.cnt == 4'd9) begin
                        st_d.cnt      = 4'd0;
                        st_d.byte_idx = 1'b0;
                        if (st_q.ash[0]) begin
                            st_d.phase = PH_RDATA;
                            st_d.rsh   = st_q.inreg;
                            st_d.oe    = !st_q.inreg[REG_W-1];
                        end else begin
                            st_d.phase = PH_WDATA;
                            st_d.oe    = 1'b0;
                        end
                    end
                end
                PH_WDATA: begin
                    if (st_q.cnt == 4'd8) begin
                        st_d.oe = 1'b1;
                    end else if (st_q.cnt == 4'd9) begin
                        st_d.oe  = 1'b0;
                        st_d.cnt = 4'd0;
                        if (!st_q.byte_idx) begin
                            st_d.byte_idx = 1'b1;
                        end else begin
                            st_d.phase    = PH_DONE;
                            st_d.dac_pd   = st_q.inreg[PD_POS];
                            st_d.dac_code = st_q.inreg[CODE_LSB +: CODE_W];
                        end
                    end
                end
                PH_RDATA: begin
                    if (st_q.cnt >= 4'd1 && st_q.cnt <= 4'd7) begin
                        st_d.rsh = {st_q.rsh[REG_W-2:0], 1'b0};
                        st_d.oe  = !st_q.rsh[REG_W-2];
                    end else if (st_q.cnt == 4'd8) begin
                        st_d.rsh = {st_q.rsh[REG_W-2:0], 1'b0};
                        st_d.oe  = 1'b0;
                    end else if (st_q.cnt == 4'd9) begin
                        st_d.cnt = 4'd0;
                        if (!st_q.byte_idx && st_q.mack) begin
                            st_d.byte_idx = 1'b1;
                            st_d.oe       = !st_q.rsh[REG_W-1];
                        end else begin
                            st_d.phase = PH_DONE;
                            st_d.oe    = 1'b0;
                            if (st_q.byte_idx) st_d.inreg = '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: 4'd0, byte_idx: 1'b0, oe: 1'b0,
                      mack: 1'b0, ash: 8'd0, inreg: '0, rsh: '0,
                      dac_pd: 1'b0, dac_code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe_o   = st_q.oe;
    assign dac_code_o = st_q.dac_code;
    assign soft_pd_o  = st_q.dac_pd;

    logic             ev_fall_w, ev_start_w, wr_last_w, oe_w;
    logic [CODE_W:0]  out_w;
    phase_e           ph_w;
    logic [3:0]       cnt_w;
    assign ev_fall_w  = evt_i.fall;
    assign ev_start_w = evt_i.start;
    assign wr_last_w  = (st_q.phase == PH_WDATA) && st_q.byte_idx;
    assign oe_w       = st_q.oe;
    assign out_w      = {st_q.dac_pd, st_q.dac_code};
    assign ph_w       = st_q.phase;
    assign cnt_w      = st_q.cnt;

    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_w |=> (ph_w == PH_ADDR && cnt_w == 4'd0 && !oe_w)); // R2

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_w) |-> $past(ev_fall_w)); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_w == PH_IDLE || ph_w == PH_DONE) |-> !oe_w); // R4

    AST_OUT_AFTER_LAST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_w) |-> $past(ev_fall_w && wr_last_w)); // R5

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w <= 4'd9); // R11

endmodule

// File: rtl/isink_dac_link.sv
module isink_dac_link
    import sdac_pkg::*;
#(
    parameter int         FILT_LEN = 6,
    parameter logic [6:0] DEV_ADDR = 7'b0001100,
    parameter int         DC_BITS  = 2,
    parameter int         CODE_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              pd_pin_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              pwr_down_o
);
    localparam int N_LINES  = 2;
    localparam int REG_W    = 16;
    localparam int PD_POS   = REG_W - 1;
    localparam int CODE_LSB = PD_POS - 1 - CODE_W;

    logic [N_LINES-1:0] raw_w;
    logic [N_LINES-1:0] filt_w;
    bus_evt_t           evt_w;
    logic               soft_pd_w;

    assign raw_w = {sda_i, scl_i};

    for (genvar li = 0; li < N_LINES; li++) begin : g_line
        sdac_line_filter #(.FILT_LEN(FILT_LEN)) flt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_w[li]),
            .line_o (filt_w[li])
        );
    end

    sdac_bus_events evt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (filt_w[0]),
        .sda_f (filt_w[1]),
        .evt_o (evt_w)
    );

    sdac_xfer_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .DC_BITS  (DC_BITS),
        .REG_W    (REG_W),
        .CODE_W   (CODE_W),
        .CODE_LSB (CODE_LSB),
        .PD_POS   (PD_POS)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_w),
        .sda_oe_o   (sda_oe_o),
        .dac_code_o (dac_code_o),
        .soft_pd_o  (soft_pd_w)
    );

    assign pwr_down_o = pd_pin_i | soft_pd_w;

endmodule

// File: tb/isink_dac_link_tb.sv
module isink_dac_link_tb_top;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pd_pin = 1'b0;
    logic       sda_oe;
    logic       sda_bus;
    logic [9:0] code;
    logic       pwr_dn;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    isink_dac_link dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_bus),
        .sda_oe_o   (sda_oe),
        .pd_pin_i   (pd_pin),
        .dac_code_o (code),
        .pwr_down_o (pwr_dn)
    );

    // {addr, hi, lo, expected code, expected soft power-down}
    localparam int NV = 5;
    localparam logic [34:0] VEC_TBL [NV] = '{
        {8'h18, 8'h3F, 8'hF0, 10'h3FF, 1'b0},
        {8'h1A, 8'h80, 8'h00, 10'h000, 1'b1},
        {8'h1C, 8'h12, 8'h34, 10'h123, 1'b0},
        {8'h1E, 8'hEA, 8'hBF, 10'h2AB, 1'b1},
        {8'h18, 8'h00, 8'h1F, 10'h001, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic clock_bit(input logic b, input logic glitch, output logic r);
        sda_m = b;
        wq(Q);
        scl_m = 1'b1;
        if (glitch) begin
            wq(5); sda_m = ~b; wq(3); sda_m = b; wq(Q - 8);
        end else begin
            wq(Q);
        end
        r = sda_bus;
        wq(Q);
        scl_m = 1'b0;
        if (glitch) begin
            wq(5); scl_m = 1'b1; wq(3); scl_m = 1'b0; wq(Q - 8);
        end else begin
            wq(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], glitch, r);
        clock_bit(1'b1, 1'b0, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic r;
        v = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, 1'b0, r);
            v = {v[6:0], r};
        end
        clock_bit(~mack, 1'b0, r);
    endtask

    task automatic write_frame(input logic [7:0] a, input logic [7:0] h, input logic [7:0] l,
                               input logic glitch, output logic [2:0] acks);
        bus_start();
        send_byte(a, 1'b0, acks[2]);
        send_byte(h, 1'b0, acks[1]);
        send_byte(l, glitch, acks[0]);
        bus_stop();
    endtask

    task automatic read_frame(input logic [7:0] a, output logic ack,
                              output logic [7:0] b0, output logic [7:0] b1);
        bus_start();
        send_byte(a, 1'b0, ack);
        recv_byte(1'b1, b0);
        recv_byte(1'b0, b1);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [2:0] acks;
        logic       a;
        logic [7:0] b0, b1;

        wq(10);
        rst_n = 1'b1;
        wq(10);
        chk("R9 code after reset", 32'(code), 32'h0);
        chk("R9 pwr_down after reset", 32'(pwr_dn), 32'h0);
        chk("R9 sda_oe after reset", 32'(sda_oe), 32'h0);

        pd_pin = 1'b1; #1;
        chk("R10 pin high forces pwr_down", 32'(pwr_dn), 32'h1);
        wq(1); pd_pin = 1'b0; #1;
        chk("R10 pin low releases pwr_down", 32'(pwr_dn), 32'h0);

        // R3 R5 table of writes over all four write address aliases
        for (int v = 0; v < NV; v++) begin
            write_frame(VEC_TBL[v][34:27], VEC_TBL[v][26:19], VEC_TBL[v][18:11], 1'b0, acks);
            wq(Q);
            chk($sformatf("R3 acks vec %0d", v), 32'(acks), 32'h7);
            chk($sformatf("R5 code vec %0d", v), 32'(code), 32'(VEC_TBL[v][10:1]));
            chk($sformatf("R10 pwr_down vec %0d", v), 32'(pwr_dn), 32'(VEC_TBL[v][0]));
        end

        // R4 wrong address: no acknowledge, output kept
        write_frame(8'h38, 8'h3F, 8'hF0, 1'b0, acks);
        wq(Q);
        chk("R4 wrong address acks", 32'(acks), 32'h0);
        chk("R4 wrong address code kept", 32'(code), 32'h001);

        // R6 stop after first data byte aborts
        bus_start();
        send_byte(8'h18, 1'b0, a);
        send_byte(8'h3C, 1'b0, a);
        bus_stop();
        wq(Q);
        chk("R6 stop abort code kept", 32'(code), 32'h001);

        // R2 R6 repeated start mid-transfer, then complete write
        bus_start();
        send_byte(8'h18, 1'b0, a);
        send_byte(8'h11, 1'b0, a);
        bus_start();
        send_byte(8'h18, 1'b0, acks[2]);
        send_byte(8'h22, 1'b0, acks[1]);
        chk("R6 code kept before second ack", 32'(code), 32'h001);
        send_byte(8'h30, 1'b0, acks[0]);
        bus_stop();
        wq(Q);
        chk("R2 restart acks", 32'(acks), 32'h7);
        chk("R2 restart code", 32'(code), 32'h223);

        // R11 extra byte not acknowledged
        bus_start();
        send_byte(8'h18, 1'b0, acks[2]);
        send_byte(8'h01, 1'b0, acks[1]);
        send_byte(8'h23, 1'b0, acks[0]);
        send_byte(8'h45, 1'b0, a);
        bus_stop();
        wq(Q);
        chk("R11 two data acks", 32'(acks), 32'h7);
        chk("R11 third byte nack", 32'(a), 32'h0);
        chk("R11 code from first two bytes", 32'(code), 32'h012);

        // R1 spikes on both lines during second data byte
        write_frame(8'h18, 8'h5A, 8'hC3, 1'b1, acks);
        wq(Q);
        chk("R1 glitch write acks", 32'(acks), 32'h7);
        chk("R1 glitch write code", 32'(code), 32'h1AC);

        // R7 read back, R8 clear afterwards
        read_frame(8'h1B, a, b0, b1);
        wq(Q);
        chk("R7 read address ack", 32'(a), 32'h1);
        chk("R7 read high byte", 32'(b0), 32'h5A);
        chk("R7 read low byte", 32'(b1), 32'hC3);
        chk("R8 read leaves code", 32'(code), 32'h1AC);
        read_frame(8'h1D, a, b0, b1);
        wq(Q);
        chk("R8 cleared high byte", 32'(b0), 32'h00);
        chk("R8 cleared low byte", 32'(b1), 32'h00);
        chk("R7 sda released at stop", 32'(sda_oe), 32'h0);

        // R10 pin held across a write that clears the soft flag
        write_frame(8'h18, 8'h80, 8'h40, 1'b0, acks);
        wq(Q);
        chk("R10 soft flag set", 32'(pwr_dn), 32'h1);
        pd_pin = 1'b1;
        write_frame(8'h18, 8'h00, 8'h40, 1'b0, acks);
        wq(Q);
        chk("R10 pin keeps pwr_down over update", 32'(pwr_dn), 32'h1);
        chk("R5 code after soft clear", 32'(code), 32'h004);
        pd_pin = 1'b0; #1;
        chk("R10 pwr_down follows cleared flag", 32'(pwr_dn), 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule